// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous memory's address register. On a load cycle it captures a full start address, the access type (read or write) and the burst ordering. On each advance cycle after that it steps the low address bits through a fixed-length burst. The upper address bits do not change during the burst.

Two orderings are available. Linear order counts up from the start value and wraps within the low bits. Interleaved order XORs the start value with a beat index that counts up from zero. The access type and the ordering are sampled only when a burst is loaded, and they apply to every beat of that burst. A hold input stops the whole block for as long as it is high. The block is used by driving a load with all selects active. Advances follow for as long as the burst should run. The counter keeps wrapping past the last beat, and a one-cycle flag is raised each time it wraps.

All inputs and outputs are plain control pins with no handshake. Every output comes from a register and changes one clock after the cycle that caused the change.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `active`, `word_addr`, `burst_wr` and `wrap_pulse` are all 0 until the first load.
- R2: A load is a clock with `hold`=0, `advance`=0 and every bit of `sel` at 1. After a load, `word_addr` equals the `addr_in` sampled at that clock, `burst_wr` equals the sampled `wr_req`, and `active` is 1.
- R3: A burst loaded with `seq_mode`=0 uses linear order. After the k-th advance, the low `BURST_BITS` of `word_addr` are (start + k) modulo 2^`BURST_BITS`.
- R4: A burst loaded with `seq_mode`=1 uses interleaved order. After the k-th advance, the low bits are start XOR (k modulo 2^`BURST_BITS`). For a start of 01 with 2 burst bits, the order is 01, 00, 11, 10.
- R5: Bits `ADDR_W-1:BURST_BITS` of `word_addr` do not change during a burst. This also holds when the low bits wrap.
- R6: An advance is a clock with `hold`=0 and `advance`=1. During an active burst it steps the sequence whatever the values of `sel` and `wr_req`. `burst_wr` keeps the value sampled at the load.
- R7: While `hold`=1, `word_addr`, `burst_wr` and `active` keep their values, and `wrap_pulse` is 0.
- R8: A clock with `hold`=0, `advance`=0 and any `sel` bit at 0 is a deselect, after which `active` is 0. An advance while `active` is 0 leaves `active` at 0 and `word_addr` unchanged.
- R9: The beat counter wraps without limit. `wrap_pulse` is 1 for exactly the one cycle that follows an advance which returns the beat index to 0. Otherwise it is 0.
- R10: `seq_mode` is sampled only at a load. Changing it during a burst does not alter the order of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | 1 freezes all state for this clock |
| advance | input | 1 | 1 = step the burst, 0 = load or deselect |
| seq_mode | input | 1 | Burst order sampled at load: 0 linear, 1 interleaved |
| wr_req | input | 1 | Access type sampled at load: 1 write, 0 read |
| sel | input | NUM_SEL | Selects; a load needs every bit at 1 |
| addr_in | input | ADDR_W | Start address |
| word_addr | output | ADDR_W | Current word address |
| burst_wr | output | 1 | Access type of the current burst |
| active | output | 1 | A burst is in progress |
| wrap_pulse | output | 1 | One-cycle flag after the beat index wraps to 0 |

## Verification
The bench builds the block with `ADDR_W`=12, `NUM_SEL`=2 and `BURST_BITS`=2. A 12-bit address makes it easy to check that upper bits such as 0xA5 stay intact while the low bits wrap. With two selects, a load can be refused by clearing just one of them. Two burst bits give a four-beat cycle, so the interleaved example and several full wraps can each be reached in a few clocks.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2,
  localparam int HI_W      = ADDR_W - BURST_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [ADDR_W-1:0]     addr_in,
  output logic [HI_W-1:0]       base_q,
  output logic [BURST_BITS-1:0] start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
    end else if (capture) begin
      base_q  <= addr_in[ADDR_W-1:BURST_BITS];
      start_q <= addr_in[BURST_BITS-1:0];
    end
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold,
  input  logic                  advance,
  input  logic                  sel_ok,
  input  logic                  wr_req,
  input  logic                  seq_mode,
  output logic                  active_q,
  output logic                  wr_q,
  output order_e                order_q,
  output logic [BURST_BITS-1:0] beat_q,
  output logic                  wrap_q
);
  localparam logic [BURST_BITS-1:0] LAST_BEAT = '1;

  logic do_load, do_desel, do_step;

  always_comb begin
    do_load  = !hold && !advance && sel_ok;
    do_desel = !hold && !advance && !sel_ok;
    do_step  = !hold && advance && active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      order_q  <= ORD_LINEAR;
      beat_q   <= '0;
      wrap_q   <= 1'b0;
    end else begin
      wrap_q <= do_step && (beat_q == LAST_BEAT);
      if (do_load) begin
        active_q <= 1'b1;
        wr_q     <= wr_req;
        order_q  <= seq_mode ? ORD_INTERLEAVE : ORD_LINEAR;
        beat_q   <= '0;
      end else if (do_desel) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else if (do_step) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_seq_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  order_e                order,
  input  logic [BURST_BITS-1:0] start,
  input  logic [BURST_BITS-1:0] beat,
  output logic [BURST_BITS-1:0] low_bits
);
  logic [BURST_BITS-1:0] lin_bits;
  logic [BURST_BITS-1:0] ilv_bits;

  assign lin_bits = start + beat;

  for (genvar i = 0; i < BURST_BITS; i++) begin : g_ilv
    assign ilv_bits[i] = start[i] ^ beat[i];
  end

  always_comb begin
    low_bits = (order == ORD_INTERLEAVE) ? ilv_bits : lin_bits;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int NUM_SEL    = 3,
  parameter int BURST_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               advance,
  input  logic               seq_mode,
  input  logic               wr_req,
  input  logic [NUM_SEL-1:0] sel,
  input  logic [ADDR_W-1:0]  addr_in,
  output logic [ADDR_W-1:0]  word_addr,
  output logic               burst_wr,
  output logic               active,
  output logic               wrap_pulse
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic                  sel_ok;
  logic                  capture;
  logic [HI_W-1:0]       base_q;
  logic [BURST_BITS-1:0] start_q;
  logic [BURST_BITS-1:0] beat_q;
  logic [BURST_BITS-1:0] low_bits;
  order_e                order_q;

  assign sel_ok  = &sel;
  assign capture = !hold && !advance && sel_ok;

  burst_addr_reg #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_areg (
    .clk(clk), .rst_n(rst_n), .capture(capture), .addr_in(addr_in),
    .base_q(base_q), .start_q(start_q)
  );

  burst_ctrl #(.BURST_BITS(BURST_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold(hold), .advance(advance),
    .sel_ok(sel_ok), .wr_req(wr_req), .seq_mode(seq_mode),
    .active_q(active), .wr_q(burst_wr), .order_q(order_q),
    .beat_q(beat_q), .wrap_q(wrap_pulse)
  );

  burst_order #(.BURST_BITS(BURST_BITS)) u_ord (
    .order(order_q), .start(start_q), .beat(beat_q), .low_bits(low_bits)
  );

  assign word_addr = {base_q, low_bits};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W     = 20,
  parameter int NUM_SEL    = 3,
  parameter int BURST_BITS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hold,
  input logic               advance,
  input logic               seq_mode,
  input logic               wr_req,
  input logic [NUM_SEL-1:0] sel,
  input logic [ADDR_W-1:0]  addr_in,
  input logic [ADDR_W-1:0]  word_addr,
  input logic               burst_wr,
  input logic               active,
  input logic               wrap_pulse
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_clear_chk: assert (!active && !wrap_pulse && !burst_wr && word_addr == '0);
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !advance && &sel) |=> (active && word_addr == $past(addr_in) && burst_wr == $past(wr_req)));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance) |=> (word_addr[ADDR_W-1:BURST_BITS] == $past(word_addr[ADDR_W-1:BURST_BITS])));

  // R6
  type_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance) |=> $stable(burst_wr));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(word_addr) && $stable(burst_wr) && $stable(active) && !wrap_pulse));

  // R8
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !advance && !(&sel)) |=> !active);

  // R8
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance && !active) |=> (!active && $stable(word_addr)));

  // R9
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && BURST_BITS > 1) |=> !wrap_pulse);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL), .BURST_BITS(BURST_BITS)
) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 12;
  localparam int NS = 2;
  localparam int BB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b0;
  logic          advance = 1'b0;
  logic          seq_mode = 1'b0;
  logic          wr_req = 1'b0;
  logic [NS-1:0] sel = '0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_addr;
  logic          burst_wr, active, wrap_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .NUM_SEL(NS), .BURST_BITS(BB)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .hold(hold), .advance(advance),
    .seq_mode(seq_mode), .wr_req(wr_req), .sel(sel), .addr_in(addr_in),
    .word_addr(word_addr), .burst_wr(burst_wr), .active(active),
    .wrap_pulse(wrap_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, then wait one full clock to the next negedge
  task automatic cyc(input logic h, input logic adv, input logic m, input logic w,
                     input logic [NS-1:0] s, input logic [AW-1:0] a);
    hold = h; advance = adv; seq_mode = m; wr_req = w; sel = s; addr_in = a;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input logic ilv, input int k);
    logic [BB-1:0] lo;
    lo = ilv ? (st[BB-1:0] ^ BB'(k)) : BB'(int'(st[BB-1:0]) + k);
    return {st[AW-1:BB], lo};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 active in reset", active, 0);
    chk("R1 addr in reset", word_addr, 0);
    rst_n = 1'b1;
    cyc(0, 1, 0, 1, '1, 12'hFFF);
    chk("R1 active after reset", active, 0);
    chk("R1 wr after reset", burst_wr, 0);
    chk("R1 wrap after reset", wrap_pulse, 0);
  endtask

  task automatic t_linear();
    logic [AW-1:0] st = 12'hA5D;
    cyc(0, 0, 0, 1, '1, st);
    chk("R2 load addr", word_addr, st);
    chk("R2 load wr", burst_wr, 1);
    chk("R2 load active", active, 1);
    for (int k = 1; k <= 3; k++) begin
      // R6: selects and wr_req toggled during advances
      cyc(0, 1, 0, k[0], NS'(k), 12'h000);
      chk("R3 linear step", word_addr, exp_addr(st, 0, k));
      chk("R5 upper bits", word_addr[AW-1:BB], st[AW-1:BB]);
      chk("R6 wr kept", burst_wr, 1);
      chk("R9 no wrap mid", wrap_pulse, 0);
    end
    cyc(0, 1, 0, 0, '0, 12'h000);
    chk("R3 linear wrap", word_addr, st);
    chk("R9 wrap pulse", wrap_pulse, 1);
    cyc(0, 1, 0, 0, '1, 12'h000);
    chk("R9 wrap pulse one cycle", wrap_pulse, 0);
    chk("R9 continues", word_addr, exp_addr(st, 0, 5));
  endtask

  task automatic t_interleave();
    logic [AW-1:0] st = 12'h3C1;
    cyc(0, 0, 1, 0, '1, st);
    chk("R4 load", word_addr, st);
    chk("R2 read type", burst_wr, 0);
    cyc(0, 1, 0, 1, '1, 0);  // R10 mode change ignored
    chk("R4 beat1 00", word_addr[BB-1:0], 2'b00);
    cyc(0, 1, 0, 1, '1, 0);
    chk("R4 beat2 11", word_addr[BB-1:0], 2'b11);
    chk("R10 mode latched", word_addr, exp_addr(st, 1, 2));
    cyc(0, 1, 0, 1, '1, 0);
    chk("R4 beat3 10", word_addr[BB-1:0], 2'b10);
    chk("R6 read kept", burst_wr, 0);
    cyc(0, 1, 0, 1, '1, 0);
    chk("R4 wrap", word_addr, st);
    chk("R9 ilv wrap", wrap_pulse, 1);
  endtask

  task automatic t_hold();
    logic [AW-1:0] st = 12'h7F2;
    cyc(0, 0, 0, 1, '1, st);
    cyc(0, 1, 0, 1, '1, 0);
    cyc(1, 1, 1, 0, '0, 12'h111);
    chk("R7 hold addr", word_addr, exp_addr(st, 0, 1));
    chk("R7 hold wr", burst_wr, 1);
    cyc(1, 0, 1, 0, '1, 12'h222);
    chk("R7 hold ignores load", word_addr, exp_addr(st, 0, 1));
    chk("R7 hold active", active, 1);
    cyc(0, 1, 0, 0, '1, 0);
    chk("R7 resumes", word_addr, exp_addr(st, 0, 2));
    cyc(0, 1, 0, 0, '1, 0);
    cyc(1, 1, 0, 0, '1, 0);
    chk("R7 pending wrap under hold", wrap_pulse, 0);
    chk("R7 no step under hold", word_addr, exp_addr(st, 0, 3));
  endtask

  task automatic t_deselect();
    logic [AW-1:0] keep;
    cyc(0, 0, 0, 1, 2'b01, 12'h456);
    chk("R8 desel active", active, 0);
    keep = word_addr;
    cyc(0, 1, 0, 1, '1, 12'h999);
    chk("R8 idle advance active", active, 0);
    chk("R8 idle advance addr", word_addr, keep);
    cyc(0, 0, 1, 1, '1, 12'h456);
    chk("R8 reload", word_addr, 12'h456);
    chk("R8 reload active", active, 1);
    cyc(0, 1, 0, 0, '1, 0);
    chk("R8 reload step", word_addr, exp_addr(12'h456, 1, 1));
  endtask

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_hold();
    t_deselect();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule